// File: doc/BRIEF.md
# CAN Receive FIFO with Run-Time Depth

This block queues accepted CAN frames in a chain of message slots and hands them to a reader oldest-first. Each slot holds a 14-byte image of one frame. The image has a control byte, four identifier bytes, a length byte and eight data bytes. Two slots always receive. Six more programmable slots follow them in a fixed chain, and a direction vector marks each of these slots as transmit or receive. The first programmable slot marked transmit ends the queue, so the usable depth runs from 2 to 8 and can change while the block is running.

An acceptance stage in front of the block writes frames with a one-cycle valid strobe. That stage carries the identifier, the extended-frame flag, the length code, the payload and the index of the filter that matched. Any filter can write into any slot. The reader sees the head slot on the output ports and removes it with a pop strobe. Full, empty, occupancy and configured depth are visible at all times. A frame that arrives while the queue is full is lost and raises a sticky overflow flag.

Top module: `canRxFifo`

## Requirements
- R1: `cfgDepth` equals 2 plus the number of low-order `dirCfg` bits, counted upward from bit 0, that are 0 before the first 1 (bit k = 1 marks programmable slot k as transmit). It is 8 when `dirCfg` is all zero. It follows `dirCfg` in the same cycle.
- R2: Frames leave in the order they were written. Both pointers wrap at `cfgDepth`, not at the largest depth.
- R3: When `fifoCount` equals `cfgDepth`, `fifoFull` is 1. A further write is dropped and leaves every stored frame and the count unchanged.
- R4: A write dropped because the queue is full sets `overflow` on the next edge. `overflow` stays set until a cycle with `ovfClr` = 1 and no new dropped write.
- R5: A pop while `fifoEmpty` is 1 is ignored. While the queue is empty, bit 7 of `rdCtrl` is 0.
- R6: In a cycle where `dirCfg` differs from its value in the previous cycle, both pointers reset. The queue is empty from the next edge on, and any write or pop in that cycle is ignored.
- R7: Identifier bytes are built from SID and EID. For an extended frame (`wrExt` = 1), SID = id[28:18] and EID = id[17:0]. For a standard frame, SID = id[10:0] and EID = 0. The bytes are `rdSidh` = SID[10:3], `rdSidl` = {SID[2:0], 0, ext, 0, EID[17:16]}, `rdEidh` = EID[15:8] and `rdEidl` = EID[7:0].
- R8: `rdCtrl` = {1, 000, filter index}. `rdDlc` = {0000, dlc}. Data byte k sits on `rdData[8k+7:8k]`, exactly as written.
- R9: `fifoCount` gives the number of stored frames. `fifoEmpty` is 1 exactly when it is 0, and both flags are never 1 together. A write or pop takes effect at the clock edge on which its strobe is sampled.
- R10: After reset the queue is empty, the count is 0 and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dirCfg | input | 6 | Direction per programmable slot, 1 = transmit |
| wrValid | input | 1 | Write strobe from the acceptance stage |
| wrExt | input | 1 | Frame uses a 29-bit identifier |
| wrId | input | 29 | Identifier (standard frames use bits 10:0) |
| wrDlc | input | 4 | Data length code |
| wrData | input | 64 | Payload, byte 0 in bits 7:0 |
| wrFilt | input | 4 | Index of the accepting filter |
| popStrobe | input | 1 | Remove the head frame |
| ovfClr | input | 1 | Clear the overflow flag |
| rdCtrl | output | 8 | Head control byte |
| rdSidh | output | 8 | Head standard identifier high byte |
| rdSidl | output | 8 | Head standard identifier low byte with flags |
| rdEidh | output | 8 | Head extended identifier high byte |
| rdEidl | output | 8 | Head extended identifier low byte |
| rdDlc | output | 8 | Head length byte |
| rdData | output | 64 | Head payload |
| fifoFull | output | 1 | Queue holds cfgDepth frames |
| fifoEmpty | output | 1 | Queue holds no frame |
| fifoCount | output | 4 | Number of stored frames |
| cfgDepth | output | 4 | Depth set by dirCfg |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
Some properties are checked on every cycle:
- the flags never contradict each other;
- the count stays within the configured depth and matches a full or empty flag;
- the head control byte agrees with the empty flag;
- a direction change always leaves the queue empty;
- a dropped write always sets the overflow flag, which then holds until cleared.

Frame order, wrap at depths other than 8, the identifier and control byte encodings, and the survival of stored frames across a dropped write can only be shown by the bench. It does this with a scoreboard of expected frame images driven through several configured depths.

// File: rtl/canRxFifoPkg.sv
package canRxFifoPkg;

  localparam int BASE_RX    = 2;   // slots that always receive
  localparam int DATA_BYTES = 8;
  localparam int FILT_W     = 4;
  localparam int ID_W       = 29;
  localparam int SID_W      = 11;
  localparam int EID_W      = 18;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoStrobeT;

  typedef struct packed {
    logic [7:0]              ctrl;
    logic [7:0]              sidh;
    logic [7:0]              sidl;
    logic [7:0]              eidh;
    logic [7:0]              eidl;
    logic [7:0]              dlc;
    logic [8*DATA_BYTES-1:0] data;
  } rxEntryT;

  // Builds the stored image of an accepted frame.
  function automatic rxEntryT buildEntry(
    input logic                    ext,
    input logic [ID_W-1:0]         id,
    input logic [3:0]              dlcIn,
    input logic [8*DATA_BYTES-1:0] payload,
    input logic [FILT_W-1:0]       filt
  );
    rxEntryT e;
    logic [SID_W-1:0] sid;
    logic [EID_W-1:0] eid;
    sid = ext ? id[ID_W-1:EID_W] : id[SID_W-1:0];
    eid = ext ? id[EID_W-1:0] : '0;
    e.ctrl = {1'b1, {(7-FILT_W){1'b0}}, filt};
    e.sidh = sid[10:3];
    e.sidl = {sid[2:0], 1'b0, ext, 1'b0, eid[17:16]};
    e.eidh = eid[15:8];
    e.eidl = eid[7:0];
    e.dlc  = {4'b0000, dlcIn};
    e.data = payload;
    return e;
  endfunction

endpackage

// File: rtl/canRxFifoCtrl.sv
module canRxFifoCtrl
  import canRxFifoPkg::*;
#(
  parameter int NUM_PROG = 6,
  localparam int MAX_DEPTH = BASE_RX + NUM_PROG,
  localparam int PTR_W     = $clog2(MAX_DEPTH),
  localparam int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PROG-1:0] dirCfg,
  input  logic                wrValid,
  input  logic                popStrobe,
  input  logic                ovfClr,
  output fifoStrobeT          strobe,
  output logic [PTR_W-1:0]    wrIdx,
  output logic [PTR_W-1:0]    rdIdx,
  output logic [CNT_W-1:0]    cfgDepth,
  output logic [CNT_W-1:0]    fifoCount,
  output logic                fifoFull,
  output logic                fifoEmpty,
  output logic                overflow
);

  logic [NUM_PROG-1:0] dirQ;
  logic [PTR_W-1:0]    wrPtr, rdPtr;
  logic                lastWr;
  logic                ovfQ;
  logic [CNT_W-1:0]    depthLive;
  logic [PTR_W-1:0]    lastIdx;
  logic                cfgChange, isFull, isEmpty, ptrEq;
  logic                doPush, doPop;

  // Depth: the first transmit slot in the chain cuts the queue.
  always_comb begin
    logic hit;
    hit       = 1'b0;
    depthLive = CNT_W'(MAX_DEPTH);
    for (int k = 0; k < NUM_PROG; k++) begin
      if (!hit && dirCfg[k]) begin
        depthLive = CNT_W'(BASE_RX + k);
        hit       = 1'b1;
      end
    end
  end

  assign lastIdx   = PTR_W'(depthLive - CNT_W'(1));
  assign cfgChange = (dirCfg != dirQ);
  assign ptrEq     = (wrPtr == rdPtr);
  assign isFull    = ptrEq && lastWr;
  assign isEmpty   = ptrEq && !lastWr;
  assign doPush    = !cfgChange && wrValid && !isFull;
  assign doPop     = !cfgChange && popStrobe && !isEmpty;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p,
                                               input logic [PTR_W-1:0] lim);
    return (p == lim) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ   <= '0;
      wrPtr  <= '0;
      rdPtr  <= '0;
      lastWr <= 1'b0;
      ovfQ   <= 1'b0;
    end else begin
      dirQ <= dirCfg;
      if (cfgChange) begin
        wrPtr  <= '0;
        rdPtr  <= '0;
        lastWr <= 1'b0;
      end else begin
        if (doPush) wrPtr <= stepPtr(wrPtr, lastIdx);
        if (doPop)  rdPtr <= stepPtr(rdPtr, lastIdx);
        if (doPush && !doPop)      lastWr <= 1'b1;
        else if (doPop && !doPush) lastWr <= 1'b0;
      end
      if (wrValid && isFull && !cfgChange) ovfQ <= 1'b1;
      else if (ovfClr)                     ovfQ <= 1'b0;
    end
  end

  always_comb begin
    if (isFull)
      fifoCount = depthLive;
    else if (wrPtr >= rdPtr)
      fifoCount = CNT_W'(wrPtr) - CNT_W'(rdPtr);
    else
      fifoCount = depthLive - CNT_W'(rdPtr) + CNT_W'(wrPtr);
  end

  assign strobe.push  = doPush;
  assign strobe.pop   = doPop;
  assign strobe.flush = cfgChange;
  assign wrIdx        = wrPtr;
  assign rdIdx        = rdPtr;
  assign cfgDepth     = depthLive;
  assign fifoFull     = isFull;
  assign fifoEmpty    = isEmpty;
  assign overflow     = ovfQ;

endmodule

// File: rtl/canRxFifoData.sv
module canRxFifoData
  import canRxFifoPkg::*;
#(
  parameter int NUM_PROG = 6,
  localparam int MAX_DEPTH = BASE_RX + NUM_PROG,
  localparam int PTR_W     = $clog2(MAX_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobeT       strobe,
  input  logic [PTR_W-1:0] wrIdx,
  input  logic [PTR_W-1:0] rdIdx,
  input  rxEntryT          wrEntry,
  output rxEntryT          rdEntry
);

  rxEntryT slotArr [MAX_DEPTH];

  for (genvar g = 0; g < MAX_DEPTH; g++) begin : gSlot
    rxEntryT slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (strobe.flush) begin
        slotQ.ctrl[7] <= 1'b0;
      end else if (strobe.push && wrIdx == PTR_W'(g)) begin
        slotQ <= wrEntry;
      end else if (strobe.pop && rdIdx == PTR_W'(g)) begin
        slotQ.ctrl[7] <= 1'b0;   // slot released
      end
    end
    assign slotArr[g] = slotQ;
  end

  assign rdEntry = slotArr[rdIdx];

endmodule

// File: rtl/canRxFifo.sv
module canRxFifo
  import canRxFifoPkg::*;
#(
  parameter int NUM_PROG = 6,
  localparam int MAX_DEPTH = BASE_RX + NUM_PROG,
  localparam int PTR_W     = $clog2(MAX_DEPTH),
  localparam int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_PROG-1:0]     dirCfg,
  input  logic                    wrValid,
  input  logic                    wrExt,
  input  logic [ID_W-1:0]         wrId,
  input  logic [3:0]              wrDlc,
  input  logic [8*DATA_BYTES-1:0] wrData,
  input  logic [FILT_W-1:0]       wrFilt,
  input  logic                    popStrobe,
  input  logic                    ovfClr,
  output logic [7:0]              rdCtrl,
  output logic [7:0]              rdSidh,
  output logic [7:0]              rdSidl,
  output logic [7:0]              rdEidh,
  output logic [7:0]              rdEidl,
  output logic [7:0]              rdDlc,
  output logic [8*DATA_BYTES-1:0] rdData,
  output logic                    fifoFull,
  output logic                    fifoEmpty,
  output logic [CNT_W-1:0]        fifoCount,
  output logic [CNT_W-1:0]        cfgDepth,
  output logic                    overflow
);

  fifoStrobeT       strobe;
  logic [PTR_W-1:0] wrIdx, rdIdx;
  rxEntryT          wrEntry, rdEntry;

  assign wrEntry = buildEntry(wrExt, wrId, wrDlc, wrData, wrFilt);

  canRxFifoCtrl #(.NUM_PROG(NUM_PROG)) i_ctrl (
    .clk(clk), .rstN(rstN), .dirCfg(dirCfg), .wrValid(wrValid),
    .popStrobe(popStrobe), .ovfClr(ovfClr), .strobe(strobe),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .cfgDepth(cfgDepth),
    .fifoCount(fifoCount), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .overflow(overflow)
  );

  canRxFifoData #(.NUM_PROG(NUM_PROG)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx),
    .rdIdx(rdIdx), .wrEntry(wrEntry), .rdEntry(rdEntry)
  );

  assign rdCtrl = rdEntry.ctrl;
  assign rdSidh = rdEntry.sidh;
  assign rdSidl = rdEntry.sidl;
  assign rdEidh = rdEntry.eidh;
  assign rdEidl = rdEntry.eidl;
  assign rdDlc  = rdEntry.dlc;
  assign rdData = rdEntry.data;

endmodule

// File: rtl/canRxFifoChk.sv
module canRxFifoChk #(
  parameter int NUM_PROG = 6,
  localparam int CNT_W = $clog2(2 + NUM_PROG + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PROG-1:0] dirCfg,
  input logic                wrValid,
  input logic                ovfClr,
  input logic [7:0]          rdCtrl,
  input logic                fifoFull,
  input logic                fifoEmpty,
  input logic [CNT_W-1:0]    fifoCount,
  input logic [CNT_W-1:0]    cfgDepth,
  input logic                overflow
);

  logic [NUM_PROG-1:0] dirSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirSeen <= '0;
    else       dirSeen <= dirCfg;
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty)); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= cfgDepth); // R2
  AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> fifoCount == cfgDepth); // R3
  AST_EMPTY_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty == (fifoCount == '0)); // R9
  AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> !rdCtrl[7]); // R5
  AST_HEAD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEmpty |-> rdCtrl[7]); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (dirCfg != dirSeen) |=> fifoEmpty); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && wrValid && dirCfg == dirSeen) |=> overflow); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !ovfClr) |=> overflow); // R4
  AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cfgDepth >= CNT_W'(2) && cfgDepth <= CNT_W'(2 + NUM_PROG)); // R1

endmodule

bind canRxFifo canRxFifoChk #(.NUM_PROG(NUM_PROG)) i_chk (
  .clk(clk), .rstN(rstN), .dirCfg(dirCfg), .wrValid(wrValid),
  .ovfClr(ovfClr), .rdCtrl(rdCtrl), .fifoFull(fifoFull),
  .fifoEmpty(fifoEmpty), .fifoCount(fifoCount), .cfgDepth(cfgDepth),
  .overflow(overflow)
);

// File: tb/test_canRxFifo.sv
module test_canRxFifo;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  dirCfg = '0;
  logic        wrValid = 1'b0, wrExt = 1'b0, popStrobe = 1'b0, ovfClr = 1'b0;
  logic [28:0] wrId = '0;
  logic [3:0]  wrDlc = '0, wrFilt = '0;
  logic [63:0] wrData = '0;
  logic [7:0]  rdCtrl, rdSidh, rdSidl, rdEidh, rdEidl, rdDlc;
  logic [63:0] rdData;
  logic        fifoFull, fifoEmpty, overflow;
  logic [3:0]  fifoCount, cfgDepth;

  int checks = 0, errs = 0;
  logic [111:0] sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  canRxFifo i_canRxFifo (
    .clk(clk), .rstN(rstN), .dirCfg(dirCfg), .wrValid(wrValid),
    .wrExt(wrExt), .wrId(wrId), .wrDlc(wrDlc), .wrData(wrData),
    .wrFilt(wrFilt), .popStrobe(popStrobe), .ovfClr(ovfClr),
    .rdCtrl(rdCtrl), .rdSidh(rdSidh), .rdSidl(rdSidl), .rdEidh(rdEidh),
    .rdEidl(rdEidl), .rdDlc(rdDlc), .rdData(rdData), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .fifoCount(fifoCount), .cfgDepth(cfgDepth),
    .overflow(overflow)
  );

  task automatic chk(input string req, input logic [111:0] act, input logic [111:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected image per R7/R8.
  function automatic logic [111:0] expImage(input logic ext, input logic [28:0] id,
      input logic [3:0] dlc, input logic [63:0] d, input logic [3:0] f);
    logic [10:0] sid;
    logic [17:0] eid;
    sid = ext ? id[28:18] : id[10:0];
    eid = ext ? id[17:0] : 18'h0;
    return {4'h8, f, sid[10:3], sid[2:0], 1'b0, ext, 1'b0, eid[17:16],
            eid[15:8], eid[7:0], 4'h0, dlc, d};
  endfunction

  // Driver: offer one frame; scoreboard keeps it only if room per R3.
  task automatic pushFrame(input int n);
    logic [63:0] d;
    d = {8{8'(n * 37 + 5)}} ^ 64'h0f1e2d3c4b5a6978;
    @(negedge clk);
    wrValid = 1'b1;
    wrExt   = n[0];
    wrId    = 29'(32'h1ab3c5d7 ^ (n * 32'h01010f1));
    wrDlc   = 4'(n % 9);
    wrData  = d;
    wrFilt  = 4'(n * 3);
    if (sbQ.size() < int'(cfgDepth))
      sbQ.push_back(expImage(wrExt, wrId, wrDlc, d, wrFilt));
    @(negedge clk);
    wrValid = 1'b0;
    chk("R9 count after write", 112'(fifoCount), 112'(sbQ.size()));
  endtask

  // Monitor: compare head with scoreboard front, then pop.
  task automatic popCheck;
    logic [111:0] exp;
    @(negedge clk);
    exp = sbQ.pop_front();
    chk("R2/R7/R8 head frame", {rdCtrl, rdSidh, rdSidl, rdEidh, rdEidl, rdDlc, rdData}, exp);
    popStrobe = 1'b1;
    @(negedge clk);
    popStrobe = 1'b0;
    chk("R9 count after pop", 112'(fifoCount), 112'(sbQ.size()));
  endtask

  task automatic setDir(input logic [5:0] v, input int expDepth);
    @(negedge clk);
    dirCfg = v;
    #1 chk("R1 depth", 112'(cfgDepth), 112'(expDepth));
    @(negedge clk);
    sbQ.delete();
    chk("R6 empty after change", {fifoEmpty, fifoCount}, {1'b1, 4'd0});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset", {fifoEmpty, fifoFull, overflow, fifoCount, cfgDepth},
        {1'b1, 1'b0, 1'b0, 4'd0, 4'd8});

    // R1 depth table
    setDir(6'b000001, 2);
    setDir(6'b100000, 7);
    setDir(6'b111111, 2);
    setDir(6'b010100, 4);
    setDir(6'b000000, 8);

    // R2 wrap at depth 4
    setDir(6'b000100, 4);
    for (int i = 0; i < 3; i++) pushFrame(i);
    popCheck(); popCheck();
    for (int i = 3; i < 6; i++) pushFrame(i);
    chk("R3 full at depth 4", {fifoFull, fifoEmpty}, {1'b1, 1'b0});
    // R3/R4 dropped write
    pushFrame(99);
    chk("R4 overflow set", 112'(overflow), 112'(1));
    repeat (2) @(negedge clk);
    chk("R4 overflow sticky", 112'(overflow), 112'(1));
    for (int i = 0; i < 4; i++) popCheck();
    @(negedge clk); ovfClr = 1'b1;
    @(negedge clk); ovfClr = 1'b0;
    chk("R4 overflow cleared", 112'(overflow), 112'(0));

    // R5 pop when empty
    @(negedge clk); popStrobe = 1'b1;
    @(negedge clk); popStrobe = 1'b0;
    chk("R5 pop on empty ignored", {fifoEmpty, fifoCount, rdCtrl[7]}, {1'b1, 4'd0, 1'b0});
    pushFrame(10); popCheck();

    // R2 wrap at depth 7 and depth 2
    setDir(6'b100000, 7);
    for (int i = 20; i < 27; i++) pushFrame(i);
    chk("R3 full at depth 7", 112'(fifoFull), 112'(1));
    for (int i = 0; i < 3; i++) popCheck();
    for (int i = 30; i < 33; i++) pushFrame(i);
    for (int i = 0; i < 7; i++) popCheck();
    setDir(6'b000001, 2);
    for (int i = 40; i < 43; i++) pushFrame(i);
    chk("R4 overflow depth 2", {fifoFull, overflow}, {1'b1, 1'b1});
    popCheck(); pushFrame(44); popCheck(); popCheck();

    // R6 change with write in the same cycle
    pushFrame(50); pushFrame(51);
    @(negedge clk);
    dirCfg = 6'b000000; wrValid = 1'b1; ovfClr = 1'b1;
    @(negedge clk);
    wrValid = 1'b0; ovfClr = 1'b0;
    sbQ.delete();
    chk("R6 flush drops write", {fifoEmpty, fifoCount, rdCtrl[7]}, {1'b1, 4'd0, 1'b0});
    pushFrame(60); popCheck();

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule